// File: doc/BRIEF.md
# Funnel-Shift Align Unit

This datapath block joins two source operands into one result by funnel-shifting their concatenation. It supports three operations. The first is a 32-bit align that counts in bytes. The second is a 64-bit align that counts in bytes. The third is a 32-bit extract-word that counts in bits, in the opposite direction. All three share one bit-granular shifter. Each operation turns the raw immediate field into a bit count of its own.

For a bit count `n` and a word size `W`, the result is `(rt << n) | (rs >> (W - n))`, taken within `W` bits. A count of 0 passes `rt` through unchanged, and a count of `W` passes `rs` through unchanged. A 32-bit result is sign-extended to 64 bits. The result and the write-enable are registered: they appear one cycle after the input strobe, together with a one-cycle output valid. A destination index of zero, or the reserved operation code, suppresses the write.

Top module: `falign_unit`

## Requirements
- R1: While reset is held and until the first accepted strobe, `valid_o`, `we_o` and `result_o` are all zero.
- R2: `valid_o` is high in the cycle after a cycle with `valid_i` high, and low in the cycle after a cycle with `valid_i` low.
- R3: With `op_i` = 2'b00 (32-bit align), the count is `n = 8*imm_i[1:0]`. The result is bits 31..0 of `(rt[31:0] << n) | (rs[31:0] >> (32 - n))`, and bit 31 of that value is copied into bits 63..32.
- R4: With `op_i` = 2'b01 (64-bit align), the count is `n = 8*imm_i[2:0]`. The result is the full 64-bit `(rt << n) | (rs >> (64 - n))`, with no extension.
- R5: With `op_i` = 2'b10 (extract-word), the count is `n = 32 - imm_i[4:0]`. The result is formed as in R3, and is also sign-extended.
- R6: A count of zero yields `rt` unchanged: the sign-extended `rt[31:0]` in 32-bit operations, and the full `rt` in 64-bit operations.
- R7: A count equal to the word size yields `rs` unchanged. An extract-word with `imm_i` = 0 yields the sign-extended `rs[31:0]`.
- R8: When `rd_i` = 0, `we_o` stays low in the output cycle.
- R9: The operation code 2'b11 is reserved, and `we_o` stays low in its output cycle.
- R10: `we_o` is high only together with `valid_o`. It is high in the output cycle of every strobe with `rd_i` != 0 and `op_i` != 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe |
| op_i | input | 2 | Operation: 00 align32, 01 align64, 10 extract-word, 11 reserved |
| imm_i | input | 5 | Raw immediate field |
| rs_i | input | 64 | Source operand rs |
| rt_i | input | 64 | Source operand rt |
| rd_i | input | 5 | Destination register index |
| result_o | output | 64 | Registered result |
| we_o | output | 1 | Registered write-enable |
| valid_o | output | 1 | Output valid, one cycle per strobe |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- that `we_o` never rises without `valid_o`;
- write suppression for a zero destination and for the reserved code;
- that the upper half of every 32-bit result holds copies of its bit 31;
- both pass-through end cases.

The funnel value at interior counts can only be shown by the bench's scenarios. These compare against a double-width reference for every byte position, all 32 extract shifts, and random operands with bit 31 set.

// File: rtl/falign_pkg.sv
package falign_pkg;
  localparam int unsigned XLEN  = 64;
  localparam int unsigned HALF  = XLEN / 2;
  localparam int unsigned CNT_W = $clog2(XLEN) + 1;
  localparam int unsigned IMM_W = 5;
  localparam int unsigned REG_W = 5;

  typedef enum logic [1:0] {
    OP_ALIGN32 = 2'b00,
    OP_ALIGN64 = 2'b01,
    OP_EXTW    = 2'b10,
    OP_RSVD    = 2'b11
  } op_e;
endpackage

// File: rtl/falign_cnt_dec.sv
module falign_cnt_dec
  import falign_pkg::*;
(
  input  op_e              op_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wide_o,
  output logic             legal_o
);
  always_comb begin
    cnt_o   = '0;
    wide_o  = 1'b0;
    legal_o = 1'b1;
    unique case (op_i)
      OP_ALIGN32: cnt_o = CNT_W'({imm_i[1:0], 3'b000});
      OP_ALIGN64: begin
        cnt_o  = CNT_W'({imm_i[2:0], 3'b000});
        wide_o = 1'b1;
      end
      // extract-word counts downward from the word size
      OP_EXTW:    cnt_o = CNT_W'(HALF) - CNT_W'(imm_i);
      default:    legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/falign_funnel.sv
module falign_funnel
  import falign_pkg::*;
(
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [XLEN-1:0]  hi_o
);
  localparam int unsigned CAT_W = 2 * XLEN;

  logic [CAT_W-1:0] stage [CNT_W+1];

  // narrow operands sit at the top so a single left shift serves both sizes
  assign stage[0] = wide_i ? {rt_i, rs_i}
                           : {rt_i[HALF-1:0], rs_i[HALF-1:0], {XLEN{1'b0}}};

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    assign stage[s+1] = cnt_i[s] ? (stage[s] << (2 ** s)) : stage[s];
  end

  assign hi_o = stage[CNT_W][CAT_W-1:XLEN];
endmodule

// File: rtl/falign_fmt.sv
module falign_fmt
  import falign_pkg::*;
(
  input  logic [XLEN-1:0] hi_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] res_o
);
  logic [HALF-1:0] narrow;
  assign narrow = hi_i[XLEN-1:HALF];
  assign res_o  = wide_i ? hi_i : {{HALF{narrow[HALF-1]}}, narrow};
endmodule

// File: rtl/falign_unit.sv
module falign_unit
  import falign_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [REG_W-1:0] rd_i,
  output logic [XLEN-1:0]  result_o,
  output logic             we_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] cnt;
  logic             wide, legal;
  logic [XLEN-1:0]  hi, res;

  falign_cnt_dec u_dec (
    .op_i   (op_e'(op_i)),
    .imm_i  (imm_i),
    .cnt_o  (cnt),
    .wide_o (wide),
    .legal_o(legal)
  );

  falign_funnel u_fun (
    .rs_i  (rs_i),
    .rt_i  (rt_i),
    .wide_i(wide),
    .cnt_i (cnt),
    .hi_o  (hi)
  );

  falign_fmt u_fmt (
    .hi_i  (hi),
    .wide_i(wide),
    .res_o (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      we_o     <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      we_o    <= valid_i && legal && (rd_i != '0);
      if (valid_i) result_o <= res;
    end
  end
endmodule

// File: rtl/falign_unit_chk.sv
module falign_unit_chk
  import falign_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [1:0]       op_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  rs_i,
  input logic [XLEN-1:0]  rt_i,
  input logic [REG_W-1:0] rd_i,
  input logic [XLEN-1:0]  result_o,
  input logic             we_o,
  input logic             valid_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_WE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> valid_o);  // R10
  AST_RD_ZERO_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rd_i == '0) |=> !we_o);  // R8
  AST_RSVD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> !we_o);  // R9
  AST_NARROW_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 2'b00 || op_i == 2'b10))
      |=> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));  // R3
  AST_RT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && imm_i[2:0] == 3'b000)
      |=> (result_o == $past(rt_i)));  // R6
  AST_RS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && imm_i == '0)
      |=> (result_o[HALF-1:0] == $past(rs_i[HALF-1:0])));  // R7
endmodule

bind falign_unit falign_unit_chk u_chk (.*);

// File: tb/falign_unit_tb_top.sv
module falign_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [4:0]  imm_i = '0;
  logic [63:0] rs_i = '0, rt_i = '0;
  logic [4:0]  rd_i = '0;
  logic [63:0] result_o;
  logic        we_o, valid_o;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  falign_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .imm_i(imm_i),
    .rs_i(rs_i), .rt_i(rt_i), .rd_i(rd_i),
    .result_o(result_o), .we_o(we_o), .valid_o(valid_o)
  );

  function automatic logic [63:0] ref_res(logic [1:0] op, logic [4:0] imm,
                                          logic [63:0] rs, logic [63:0] rt);
    int unsigned n;
    logic [63:0]  a32;
    logic [127:0] a64;
    if (op == 2'b01) begin
      n   = 8 * imm[2:0];
      a64 = ({64'd0, rt} << n) | ({64'd0, rs} >> (64 - n));
      return a64[63:0];
    end
    n   = (op == 2'b00) ? 8 * imm[1:0] : 32 - imm;
    a32 = ({32'd0, rt[31:0]} << n) | ({32'd0, rs[31:0]} >> (32 - n));
    return {{32{a32[31]}}, a32[31:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [1:0] op, logic [4:0] imm,
                     logic [63:0] rs, logic [63:0] rt, logic [4:0] rd);
    op_i = op; imm_i = imm; rs_i = rs; rt_i = rt; rd_i = rd; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " R2 valid"}, 64'(valid_o), 64'd1);
    check({req, " R10 we"}, 64'(we_o), 64'((rd != 0) && (op != 2'b11)));
    if (op != 2'b11) check({req, " result"}, result_o, ref_res(op, imm, rs, rt));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(valid_o), 0);
    check("R1 we", 64'(we_o), 0);
    check("R1 result", result_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", 64'(valid_o), 0);
    check("R1 idle result", result_o, 0);

    a = 64'hF0E1_D2C3_B4A5_9687;
    b = 64'h8877_6655_4433_2211;
    for (int bp = 0; bp < 4; bp++) run("R3 align32 bp", 2'b00, 5'(bp), a, b, 5'd3);
    for (int bp = 0; bp < 8; bp++) run("R4 align64 bp", 2'b01, 5'(bp), a, b, 5'd4);
    for (int sh = 0; sh < 32; sh++) run("R5 extw sh", 2'b10, 5'(sh), a, b, 5'd5);

    run("R6 align32 rt pass", 2'b00, 5'd0, a, b, 5'd1);
    check("R6 value", result_o, 64'h0000_0000_4433_2211);
    run("R6 align64 rt pass", 2'b01, 5'd0, a, b, 5'd1);
    check("R6 value64", result_o, b);
    run("R7 extw rs pass", 2'b10, 5'd0, a, b, 5'd1);
    check("R7 value", result_o, 64'hFFFF_FFFF_B4A5_9687);
    run("R3 align32 bp1", 2'b00, 5'd1, 64'h0, 64'h0000_0000_0080_0000, 5'd2);
    check("R3 sext value", result_o, 64'hFFFF_FFFF_8000_0000);

    run("R8 rd zero", 2'b01, 5'd3, a, b, 5'd0);
    check("R8 we", 64'(we_o), 0);
    run("R9 reserved", 2'b11, 5'd7, a, b, 5'd9);
    check("R9 we", 64'(we_o), 0);

    @(negedge clk);
    check("R2 drop valid", 64'(valid_o), 0);
    check("R10 drop we", 64'(we_o), 0);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      a = rnd64(); b = rnd64();
      a[31] = 1'b1; b[31] = 1'b1;
      run("R3 R4 R5 random", op, 5'($urandom()), a, b, 5'($urandom()));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule